// File: doc/BRIEF.md
# Serial NOVRAM Command Master

This block is a hardware master for a serial nonvolatile RAM that has three wires: a chip enable, a serial clock and one data line that both sides share. A host on the system clock asks for one of three kinds of operation. The first is a bare command (recall, write-enable set and reset, store, power-down). The second reads a 16-bit word and the third writes one, each at a 4-bit word address. The master runs the whole serial frame by itself and hands the result back with a busy/done handshake.

Each request gets a frame of its own. Chip enable rises, and the master sends an 8-bit instruction most significant bit first. It then shifts out 16 write bits, or collects 16 read bits. For a read, the master stops driving the shared line after the seventh instruction bit, so the memory can answer. It drives the line again once the word is in, and only then lowers chip enable. The serial clock comes from the system clock through a divider, and each clock phase lasts a set number of system cycles. The shared line appears as three separate signals: a data-out bit, an output-enable bit and a data-in bit. A pad outside the block joins them.

Top module: `novram_cmd_master`

## Requirements
- R1: After reset `ce`, `sk` and `sioOut` are 0, `sioOe` is 1, and `busy` and `done` are 0.
- R2: A command code `cmd` other than 3 (write) or 6 (read) produces a frame of exactly 8 clocks. The frame carries the byte 0x80 | cmd, and `addr` has no effect on it.
- R3: For write (cmd 3) and read (cmd 6) the instruction byte is 0x80 | (addr << 3) | cmd, so the address sits in bits 6:3.
- R4: All bits go out most significant first and `sioOut` stays stable while `sk` is high. A write frame has 24 clocks: the instruction byte, then `wrData` bit 15 down to bit 0.
- R5: `ce` is high at every rising `sk` and `sk` is only high while `ce` is high. Each accepted request produces exactly one `ce` high period.
- R6: `sk` is 0 between frames. Every high phase and every low phase of `sk` lasts at least DIV system cycles.
- R7: In a read frame (24 clocks) `sioOe` is 1 at the first 7 rising `sk` edges and 0 at the 8th through 24th. `sioOe` is 0 only while `ce` is 1.
- R8: In a read, `sioIn` is sampled in the low phase just before rising edges 9 through 24. The samples fill `rdData` from bit 15 down to bit 0, and `rdData` holds the word once `done` pulses.
- R9: After the last read clock `sioOe` returns to 1 before `ce` falls. `sioOe` is 1 whenever `ce` is 0.
- R10: `start` is accepted only while `busy` is 0, and `busy` is 1 from the next cycle until the frame ends. `done` is a single-cycle pulse at the cycle `busy` drops. A `start` pulse while `busy` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken when not busy |
| cmd | input | 3 | Command code; instruction low bits (3 write, 6 read, others bare) |
| addr | input | 4 | Word address for read and write |
| wrData | input | DATA_W | Word to write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| rdData | output | DATA_W | Last word read |
| ce | output | 1 | Memory chip enable |
| sk | output | 1 | Serial clock to the memory |
| sioOut | output | 1 | Value driven on the shared data line |
| sioOe | output | 1 | 1 = master drives the shared data line |
| sioIn | input | 1 | Value seen on the shared data line |

## Verification
The bench models the memory from the clock edges it sees and sweeps every command code, every address for reads and writes, and several word patterns. It looks hardest at the line turnaround. A design that releases the line one clock late would fight the memory on the 8th clock. One that releases it a clock early would send a truncated opcode. One that lowers chip enable before it drives the line again would leave the line floating between frames. It also checks the read sampling point and the bit order, because sampling after the rising edge or shifting LSB first gives a shifted or reversed word. It checks that the address lands in bits 6:3 and that a start pulse during a frame does not begin a second frame.

// File: rtl/novram_pkg.sv
package novram_pkg;
  localparam int ADDR_W = 4;
  localparam logic [2:0] CMD_WRITE = 3'd3;
  localparam logic [2:0] CMD_READ  = 3'd6;

  typedef struct packed {
    logic load;      // capture request, raise ce
    logic shift;     // next bit onto the line
    logic capture;   // sample line into read word
    logic relLine;   // stop driving the line
    logic driveLine; // drive the line again, clear output
    logic ceOff;
    logic skOn;
    logic skOff;
  } strobe_t;

  function automatic logic isDataCmd(input logic [2:0] c);
    return (c == CMD_WRITE) || (c == CMD_READ);
  endfunction

  function automatic logic [7:0] makeOpcode(input logic [2:0] c, input logic [ADDR_W-1:0] a);
    logic [7:0] op;
    op = {5'b10000, c};
    if (isDataCmd(c)) op[6:3] = a;
    return op;
  endfunction
endpackage

// File: rtl/novram_ctrl.sv
module novram_ctrl
  import novram_pkg::*;
#(
  parameter int DIV    = 4,
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] cmd,
  output strobe_t    stb,
  output logic       busy,
  output logic       done
);
  localparam int NB = 8 + DATA_W;
  localparam int BW = $clog2(NB);
  localparam int TW = (DIV < 2) ? 1 : $clog2(DIV);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_FIN} state_t;

  state_t        state;
  logic [TW-1:0] timer;
  logic [BW-1:0] bitIdx, lastIdx;
  logic          isRead;
  logic          phaseEnd;

  assign phaseEnd = (timer == TW'(DIV - 1));
  assign busy     = (state != S_IDLE);

  always_comb begin
    stb = '0;
    unique case (state)
      S_IDLE: if (start) stb.load = 1'b1;
      S_LOW: if (phaseEnd) begin
        stb.skOn    = 1'b1;
        stb.capture = isRead && (bitIdx >= BW'(8));
      end
      S_HIGH: if (phaseEnd) begin
        stb.skOff = 1'b1;
        if (bitIdx == lastIdx) stb.driveLine = 1'b1;
        else begin
          stb.shift   = 1'b1;
          stb.relLine = isRead && (bitIdx == BW'(6));
        end
      end
      S_FIN: if (phaseEnd) stb.ceOff = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      timer   <= '0;
      bitIdx  <= '0;
      lastIdx <= '0;
      isRead  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          state   <= S_LOW;
          timer   <= '0;
          bitIdx  <= '0;
          isRead  <= (cmd == CMD_READ);
          lastIdx <= isDataCmd(cmd) ? BW'(NB - 1) : BW'(7);
        end
        S_LOW: begin
          if (phaseEnd) begin
            timer <= '0;
            state <= S_HIGH;
          end else timer <= timer + 1'b1;
        end
        S_HIGH: begin
          if (phaseEnd) begin
            timer <= '0;
            if (bitIdx == lastIdx) state <= S_FIN;
            else begin
              bitIdx <= bitIdx + 1'b1;
              state  <= S_LOW;
            end
          end else timer <= timer + 1'b1;
        end
        S_FIN: begin
          if (phaseEnd) begin
            timer <= '0;
            state <= S_IDLE;
            done  <= 1'b1;
          end else timer <= timer + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/novram_dp.sv
module novram_dp
  import novram_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [2:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sioIn,
  output logic              ce,
  output logic              sk,
  output logic              sioOut,
  output logic              sioOe,
  output logic [DATA_W-1:0] rdData
);
  localparam int SW = 8 + DATA_W;

  logic [SW-1:0]     outSr;
  logic [DATA_W-1:0] inSr;

  assign sioOut = outSr[SW-1];
  assign rdData = inSr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ce    <= 1'b0;
      sk    <= 1'b0;
      sioOe <= 1'b1;
      outSr <= '0;
      inSr  <= '0;
    end else begin
      if (stb.load) begin
        outSr <= {makeOpcode(cmd, addr), wrData};
        ce    <= 1'b1;
      end
      if (stb.shift)     outSr <= outSr << 1;
      if (stb.relLine)   sioOe <= 1'b0;
      if (stb.driveLine) begin
        sioOe <= 1'b1;
        outSr <= '0;
      end
      if (stb.capture) inSr <= {inSr[DATA_W-2:0], sioIn};
      if (stb.skOn)    sk <= 1'b1;
      if (stb.skOff)   sk <= 1'b0;
      if (stb.ceOff)   ce <= 1'b0;
    end
  end

  assert_sk_in_frame_R5: assert property (@(posedge clk) disable iff (!rstN)
    sk |-> ce);
  assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    sk |-> $stable(sioOut));
  assert_release_in_frame_R7: assert property (@(posedge clk) disable iff (!rstN)
    !sioOe |-> ce);
  assert_drive_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ce) |-> sioOe);
endmodule

// File: rtl/novram_cmd_master.sv
module novram_cmd_master
  import novram_pkg::*;
#(
  parameter int DIV    = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              ce,
  output logic              sk,
  output logic              sioOut,
  output logic              sioOe,
  input  logic              sioIn
);
  strobe_t stb;

  novram_ctrl #(.DIV(DIV), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd),
    .stb(stb), .busy(busy), .done(done)
  );

  novram_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmd(cmd), .addr(addr),
    .wrData(wrData), .sioIn(sioIn), .ce(ce), .sk(sk),
    .sioOut(sioOut), .sioOe(sioOe), .rdData(rdData)
  );
endmodule

// File: tb/novram_cmd_master_tb.sv
module novram_cmd_master_tb;
  localparam int DIV = 3;
  localparam int DW  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] cmd = '0;
  logic [3:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic busy, done, ce, sk, sioOut, sioOe, sioIn;
  logic [DW-1:0] rdData;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  // memory model state, updated by the monitor
  int rises = 0, loCnt = 0, hiCnt = 0, phaseBad = 0, ceBad = 0;
  int frameStarts = 0, frameEnds = 0, oeAtFallBad = 0, doneCnt = 0;
  logic [23:0] capt = '0, oeBits = '0;
  logic prevSk = 0, prevCe = 0;
  logic [DW-1:0] devWord = '0;

  always #10 clk = ~clk;

  assign sioIn = (rises >= 8 && rises < 24) ? devWord[23 - rises] : 1'b0;

  novram_cmd_master #(.DIV(DIV), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd), .addr(addr),
    .wrData(wrData), .busy(busy), .done(done), .rdData(rdData),
    .ce(ce), .sk(sk), .sioOut(sioOut), .sioOe(sioOe), .sioIn(sioIn)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (sk != prevSk) begin
        if (sk) begin
          if (loCnt < DIV) phaseBad++;
          if (!ce) ceBad++;
          capt   = {capt[22:0], sioOut};
          oeBits = {oeBits[22:0], sioOe};
          rises++;
        end else if (hiCnt < DIV) phaseBad++;
        loCnt = 0; hiCnt = 0;
      end
      if (sk) hiCnt++; else loCnt++;
      if (ce && !prevCe) frameStarts++;
      if (!ce && prevCe) begin
        frameEnds++;
        if (!sioOe) oeAtFallBad++;
      end
      if (done) doneCnt++;
      prevSk = sk; prevCe = ce;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic runCmd(input logic [2:0] c, input logic [3:0] a, input logic [DW-1:0] wd,
                        input logic [DW-1:0] dw, input bit midStart);
    bit isRw;
    int nb;
    int t;
    logic [7:0] op;
    isRw = (c == 3'd3) || (c == 3'd6);
    nb = isRw ? 24 : 8;
    op = 8'h80 | (isRw ? {1'b0, a, 3'b000} : 8'h00) | {5'b0, c};
    @(negedge clk);
    rises = 0; capt = '0; oeBits = '0; phaseBad = 0; ceBad = 0;
    frameStarts = 0; frameEnds = 0; oeAtFallBad = 0; doneCnt = 0;
    devWord = dw; cmd = c; addr = a; wrData = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10 busy after start", busy, 1);
    t = 0;
    while (!done && t < 4000) begin
      @(negedge clk);
      t++;
      if (midStart && t == 10) begin
        cmd = 3'd6; addr = ~a; start = 1'b1;
      end else start = 1'b0;
    end
    check(t < 4000, "R10 frame completes", t, 0);
    repeat (2) @(negedge clk);
    check(rises == nb, "R2/R4 clock count", rises, nb);
    if (c == 3'd6) begin
      check(capt[23:17] == op[7:1], "R3 read opcode bits", capt[23:17], op[7:1]);
      check(oeBits == 24'hFE0000, "R7 release at 8th clock", oeBits, 24'hFE0000);
      check(rdData == dw, "R8 read word", rdData, dw);
    end else if (c == 3'd3) begin
      check(capt == {op, wd}, "R3/R4 write frame", capt, {op, wd});
      check(oeBits == 24'hFFFFFF, "R7 driven throughout", oeBits, 24'hFFFFFF);
    end else begin
      check(capt[7:0] == op, "R2 bare opcode", capt[7:0], op);
      check(oeBits[7:0] == 8'hFF, "R7 driven throughout", oeBits[7:0], 8'hFF);
    end
    check(phaseBad == 0, "R6 phase length", phaseBad, 0);
    check(ceBad == 0, "R5 ce high at clocks", ceBad, 0);
    check(frameStarts == 1 && frameEnds == 1, "R5 one frame", frameStarts * 10 + frameEnds, 11);
    check(oeAtFallBad == 0, "R9 driven before ce fall", oeAtFallBad, 0);
    check(doneCnt == 1, "R10 single done", doneCnt, 1);
    check(!busy && !ce && !sk && sioOe, "R6/R9 idle lines", {busy, ce, sk, sioOe}, 4'b0001);
    if (midStart) begin
      repeat (20) @(negedge clk);
      check(frameStarts == 1 && !busy, "R10 start while busy ignored", frameStarts, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ce == 0 && sk == 0 && sioOut == 0 && sioOe == 1 && busy == 0 && done == 0,
          "R1 reset state", {ce, sk, sioOut, sioOe, busy, done}, 6'b000100);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    foreach (cmd[i]) ;
    for (int c = 0; c < 8; c++)
      if (c != 3 && c != 6) runCmd(3'(c), 4'(c * 5 + 3), 16'hFFFF, 16'h0, 0);
    for (int a = 0; a < 16; a++)
      runCmd(3'd3, 4'(a), 16'(16'h8001 ^ (a * 16'h1357)), 16'h0, 0);
    for (int a = 0; a < 16; a++)
      runCmd(3'd6, 4'(a), 16'h0, 16'(16'hA5C3 ^ (a * 16'h0F11)), 0);
    runCmd(3'd6, 4'd9, 16'h0, 16'hFFFF, 0);
    runCmd(3'd6, 4'd0, 16'h0, 16'h0001, 0);
    runCmd(3'd3, 4'd5, 16'h1234, 16'h0, 1);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule